// File: doc/BRIEF.md
# Range-Based Memory Protection Checker

This block sits beside a processor's load/store unit and its fetch unit and decides, for every data access and every instruction fetch, whether the address is allowed. Permission comes from programmable address windows: 16 windows for data and 8 windows for code. Each window has an inclusive lower bound and an exclusive upper bound. Data windows are aligned to 8 bytes and code windows to 32 bytes.

Four permission profiles hold per-window read, write and execute enable masks. One profile is active at a time. The active profile drops back to profile 0 whenever the core signals entry into an exception or interrupt. When checking is on, an access that no enabled window covers is refused in the same cycle. One cycle later a trap pulse follows, and an alarm pulse follows too if the alarm is enabled.

Configuration goes through a single write port with a readback path, so software can update a mask with read-modify-write. Writes take effect only while the supervisor input is high.

Top module: `mem_guard`

## Requirements
- R1: The configuration port addresses registers by `cfg_kind_i` and `cfg_idx_i`. Kind 0 is the data lower bound and kind 1 the data upper bound, indexed by window 0..15. Kind 2 is the code lower bound and kind 3 the code upper bound, indexed by window 0..7. Kind 4 is the read mask, kind 5 the write mask and kind 6 the execute mask, each indexed by profile 0..3. Kind 7 is the control register: bit 0 enables checking, bit 1 enables the alarm, and bits 3:2 hold the active profile. `cfg_rdata_o` returns the selected register in the same cycle, and a write is visible in readback from the cycle after its clock edge.
- R2: An address hits a window when lower <= address < upper. An address equal to the upper bound is outside the window.
- R3: On write, the low 3 bits of a data bound and the low 5 bits of a code bound are dropped, and they read back as zero. The same low bits of the access address take no part in matching.
- R4: Checking uses only the masks of the active profile. Bit i of a data mask enables data window i, and bit i of the execute mask enables code window i.
- R5: An access is allowed when at least one hit window is enabled for it. Overlapping windows combine as a logical OR, so the most permissive one wins.
- R6: A data read (`d_we_i`=0) consults only read masks, a data write (`d_we_i`=1) only write masks, and a fetch only the execute mask against the code windows.
- R7: Grant and violation are combinational in the request cycle. With a request, exactly one of them is high; without a request, both are low.
- R8: A refused access raises `trap_o` for exactly the following cycle. `alarm_o` rises together with it when the alarm enable is set.
- R9: The active profile is 0 after reset. Asserting `exc_entry_i` makes it 0 from the next cycle, and this overrides a simultaneous control write. The request in the entry cycle is still checked with the old profile.
- R10: Every configuration write is ignored while `sup_i` is low.
- R11: While the check enable is clear, every request is granted and no trap or alarm is raised.
- R12: Reset clears all bounds, masks and control bits. The reset is asynchronous, and its release is synchronised over two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sup_i | input | 1 | Supervisor mode; qualifies configuration writes |
| exc_entry_i | input | 1 | Exception or interrupt entry; forces profile 0 |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 3 | Register kind selector |
| cfg_idx_i | input | 4 | Window or profile index |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Readback of the selected register |
| d_req_i | input | 1 | Data access valid |
| d_we_i | input | 1 | Data access is a write |
| d_addr_i | input | 32 | Data access address |
| d_grant_o | output | 1 | Data access allowed |
| d_viol_o | output | 1 | Data access refused |
| f_req_i | input | 1 | Instruction fetch valid |
| f_addr_i | input | 32 | Fetch address |
| f_grant_o | output | 1 | Fetch allowed |
| f_viol_o | output | 1 | Fetch refused |
| trap_o | output | 1 | One-cycle pulse after a refused access |
| alarm_o | output | 1 | Trap pulse qualified by the alarm enable |

## Verification
Grant, violation and readback are due in the same cycle their inputs are applied. Trap and alarm are due one cycle later. A configuration write or exception entry changes checking and readback from the cycle after its clock edge. The bench drives inputs just after each rising edge and updates its reference model at the rising edge, using the inputs that were held through that cycle. It compares every output at the falling edge, so each value is sampled exactly in the cycle where the timing above places it.

// File: rtl/mg_pkg.sv
package mg_pkg;
  typedef enum logic [2:0] {
    CK_DLO = 3'd0,
    CK_DHI = 3'd1,
    CK_CLO = 3'd2,
    CK_CHI = 3'd3,
    CK_RD  = 3'd4,
    CK_WR  = 3'd5,
    CK_EX  = 3'd6,
    CK_CTL = 3'd7
  } cfg_kind_e;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_ALM_BIT = 1;
  localparam int CTL_SET_LSB = 2;
endpackage

// File: rtl/mg_bound_bank.sv
// Lower/upper bound storage for a group of address windows, kept at block granularity.
module mg_bound_bank #(
  parameter  int N     = 16,
  parameter  int AW    = 32,
  parameter  int GRAN  = 3,
  parameter  int IDX_W = 4,
  localparam int BW    = AW - GRAN
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  lo_wr_i,
  input  logic                  hi_wr_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [BW-1:0]         wblk_i,
  output logic [N-1:0][BW-1:0]  lo_o,
  output logic [N-1:0][BW-1:0]  hi_o,
  output logic [AW-1:0]         lo_rd_o,
  output logic [AW-1:0]         hi_rd_o
);
  logic [N-1:0][BW-1:0] lo_q, lo_d;
  logic [N-1:0][BW-1:0] hi_q, hi_d;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic sel;
    assign sel = (idx_i == IDX_W'(g));

    always_comb begin
      lo_d[g] = lo_q[g];
      hi_d[g] = hi_q[g];
      if (lo_wr_i && sel) lo_d[g] = wblk_i;
      if (hi_wr_i && sel) hi_d[g] = wblk_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else begin
        lo_q[g] <= lo_d[g];
        hi_q[g] <= hi_d[g];
      end
    end
  end

  always_comb begin
    lo_rd_o = '0;
    hi_rd_o = '0;
    for (int i = 0; i < N; i++) begin
      if (idx_i == IDX_W'(i)) begin
        lo_rd_o = {lo_q[i], {GRAN{1'b0}}};
        hi_rd_o = {hi_q[i], {GRAN{1'b0}}};
      end
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/mg_mask_bank.sv
// Per-profile enable masks of one access type.
module mg_mask_bank #(
  parameter int N_SETS = 4,
  parameter int NR     = 16,
  parameter int IDX_W  = 4,
  parameter int SET_W  = 2,
  parameter int DW     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [NR-1:0]    wdata_i,
  input  logic [SET_W-1:0] set_i,
  output logic [NR-1:0]    mask_o,
  output logic [DW-1:0]    rd_o
);
  logic [N_SETS-1:0][NR-1:0] msk_q, msk_d;

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    always_comb begin
      msk_d[s] = msk_q[s];
      if (wr_i && (idx_i == IDX_W'(s))) msk_d[s] = wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) msk_q[s] <= '0;
      else         msk_q[s] <= msk_d[s];
    end
  end

  always_comb begin
    mask_o = '0;
    rd_o   = '0;
    for (int s = 0; s < N_SETS; s++) begin
      if (set_i == SET_W'(s)) mask_o = msk_q[s];
      if (idx_i == IDX_W'(s)) rd_o   = DW'(msk_q[s]);
    end
  end
endmodule

// File: rtl/mg_range_hit.sv
// Parallel window compare: lower <= addr < upper, all in block units.
module mg_range_hit #(
  parameter int N  = 16,
  parameter int BW = 29
) (
  input  logic [BW-1:0]        blk_i,
  input  logic [N-1:0][BW-1:0] lo_i,
  input  logic [N-1:0][BW-1:0] hi_i,
  output logic [N-1:0]         hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_o[g] = (blk_i >= lo_i[g]) && (blk_i < hi_i[g]);
  end
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mg_pkg::*;
#(
  parameter  int AW     = 32,
  parameter  int N_DATA = 16,
  parameter  int N_CODE = 8,
  parameter  int N_SETS = 4,
  parameter  int D_GRAN = 3,
  parameter  int C_GRAN = 5,
  localparam int IDX_W  = $clog2(N_DATA),
  localparam int SET_W  = $clog2(N_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sup_i,
  input  logic             exc_entry_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_kind_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [AW-1:0]    cfg_wdata_i,
  output logic [AW-1:0]    cfg_rdata_o,
  input  logic             d_req_i,
  input  logic             d_we_i,
  input  logic [AW-1:0]    d_addr_i,
  output logic             d_grant_o,
  output logic             d_viol_o,
  input  logic             f_req_i,
  input  logic [AW-1:0]    f_addr_i,
  output logic             f_grant_o,
  output logic             f_viol_o,
  output logic             trap_o,
  output logic             alarm_o
);
  localparam int DBW = AW - D_GRAN;
  localparam int CBW = AW - C_GRAN;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= '0;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  cfg_kind_e kind;
  logic      wr_ok;
  assign kind  = cfg_kind_e'(cfg_kind_i);
  assign wr_ok = cfg_we_i && sup_i;

  // control register
  logic             prot_en_q, prot_en_d;
  logic             alm_en_q, alm_en_d;
  logic [SET_W-1:0] act_set_q, act_set_d;
  logic             ctl_wr;
  assign ctl_wr = wr_ok && (kind == CK_CTL);

  always_comb begin
    prot_en_d = prot_en_q;
    alm_en_d  = alm_en_q;
    act_set_d = act_set_q;
    if (ctl_wr) begin
      prot_en_d = cfg_wdata_i[CTL_EN_BIT];
      alm_en_d  = cfg_wdata_i[CTL_ALM_BIT];
      act_set_d = cfg_wdata_i[CTL_SET_LSB +: SET_W];
    end
    if (exc_entry_i) act_set_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      prot_en_q <= 1'b0;
      alm_en_q  <= 1'b0;
      act_set_q <= '0;
    end else begin
      prot_en_q <= prot_en_d;
      alm_en_q  <= alm_en_d;
      act_set_q <= act_set_d;
    end
  end

  // window bounds
  logic [N_DATA-1:0][DBW-1:0] d_lo, d_hi;
  logic [N_CODE-1:0][CBW-1:0] c_lo, c_hi;
  logic [AW-1:0]              d_lo_rd, d_hi_rd, c_lo_rd, c_hi_rd;

  mg_bound_bank #(.N(N_DATA), .AW(AW), .GRAN(D_GRAN), .IDX_W(IDX_W)) u_dbnd (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .lo_wr_i (wr_ok && (kind == CK_DLO)),
    .hi_wr_i (wr_ok && (kind == CK_DHI)),
    .idx_i   (cfg_idx_i),
    .wblk_i  (cfg_wdata_i[AW-1:D_GRAN]),
    .lo_o    (d_lo),
    .hi_o    (d_hi),
    .lo_rd_o (d_lo_rd),
    .hi_rd_o (d_hi_rd)
  );

  mg_bound_bank #(.N(N_CODE), .AW(AW), .GRAN(C_GRAN), .IDX_W(IDX_W)) u_cbnd (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .lo_wr_i (wr_ok && (kind == CK_CLO)),
    .hi_wr_i (wr_ok && (kind == CK_CHI)),
    .idx_i   (cfg_idx_i),
    .wblk_i  (cfg_wdata_i[AW-1:C_GRAN]),
    .lo_o    (c_lo),
    .hi_o    (c_hi),
    .lo_rd_o (c_lo_rd),
    .hi_rd_o (c_hi_rd)
  );

  // permission masks
  logic [N_DATA-1:0] rd_mask, wr_mask;
  logic [N_CODE-1:0] ex_mask;
  logic [AW-1:0]     rd_rd, wr_rd, ex_rd;

  mg_mask_bank #(.N_SETS(N_SETS), .NR(N_DATA), .IDX_W(IDX_W), .SET_W(SET_W), .DW(AW)) u_rmsk (
    .clk_i (clk_i), .rst_ni (rst_n), .wr_i (wr_ok && (kind == CK_RD)),
    .idx_i (cfg_idx_i), .wdata_i (cfg_wdata_i[N_DATA-1:0]), .set_i (act_set_q),
    .mask_o (rd_mask), .rd_o (rd_rd)
  );

  mg_mask_bank #(.N_SETS(N_SETS), .NR(N_DATA), .IDX_W(IDX_W), .SET_W(SET_W), .DW(AW)) u_wmsk (
    .clk_i (clk_i), .rst_ni (rst_n), .wr_i (wr_ok && (kind == CK_WR)),
    .idx_i (cfg_idx_i), .wdata_i (cfg_wdata_i[N_DATA-1:0]), .set_i (act_set_q),
    .mask_o (wr_mask), .rd_o (wr_rd)
  );

  mg_mask_bank #(.N_SETS(N_SETS), .NR(N_CODE), .IDX_W(IDX_W), .SET_W(SET_W), .DW(AW)) u_xmsk (
    .clk_i (clk_i), .rst_ni (rst_n), .wr_i (wr_ok && (kind == CK_EX)),
    .idx_i (cfg_idx_i), .wdata_i (cfg_wdata_i[N_CODE-1:0]), .set_i (act_set_q),
    .mask_o (ex_mask), .rd_o (ex_rd)
  );

  // readback
  always_comb begin
    unique case (kind)
      CK_DLO:  cfg_rdata_o = d_lo_rd;
      CK_DHI:  cfg_rdata_o = d_hi_rd;
      CK_CLO:  cfg_rdata_o = c_lo_rd;
      CK_CHI:  cfg_rdata_o = c_hi_rd;
      CK_RD:   cfg_rdata_o = rd_rd;
      CK_WR:   cfg_rdata_o = wr_rd;
      CK_EX:   cfg_rdata_o = ex_rd;
      default: cfg_rdata_o = AW'({act_set_q, alm_en_q, prot_en_q});
    endcase
  end

  // address matching
  logic [N_DATA-1:0] d_hit;
  logic [N_CODE-1:0] c_hit;
  logic              unused_lo;
  assign unused_lo = ^{d_addr_i[D_GRAN-1:0], f_addr_i[C_GRAN-1:0]};

  mg_range_hit #(.N(N_DATA), .BW(DBW)) u_dhit (
    .blk_i (d_addr_i[AW-1:D_GRAN]), .lo_i (d_lo), .hi_i (d_hi), .hit_o (d_hit)
  );

  mg_range_hit #(.N(N_CODE), .BW(CBW)) u_chit (
    .blk_i (f_addr_i[AW-1:C_GRAN]), .lo_i (c_lo), .hi_i (c_hi), .hit_o (c_hit)
  );

  logic d_perm, f_perm;
  assign d_perm = |(d_hit & (d_we_i ? wr_mask : rd_mask));
  assign f_perm = |(c_hit & ex_mask);

  assign d_viol_o  = d_req_i && prot_en_q && !d_perm;
  assign d_grant_o = d_req_i && !d_viol_o;
  assign f_viol_o  = f_req_i && prot_en_q && !f_perm;
  assign f_grant_o = f_req_i && !f_viol_o;

  // trap / alarm pulses
  logic trap_d, alarm_d, trap_q, alarm_q;
  assign trap_d  = d_viol_o || f_viol_o;
  assign alarm_d = trap_d && alm_en_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      trap_q  <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      trap_q  <= trap_d;
      alarm_q <= alarm_d;
    end
  end

  assign trap_o  = trap_q;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk #(
  parameter int SET_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sup_i,
  input logic             exc_entry_i,
  input logic             d_req_i,
  input logic             d_grant_o,
  input logic             d_viol_o,
  input logic             f_req_i,
  input logic             f_grant_o,
  input logic             f_viol_o,
  input logic             trap_o,
  input logic             alarm_o,
  input logic             prot_en_q,
  input logic [SET_W-1:0] act_set_q
);
  AST_DATA_ONE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_req_i |-> (d_grant_o ^ d_viol_o)); // R7
  AST_FETCH_ONE_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    f_req_i |-> (f_grant_o ^ f_viol_o)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!d_req_i && !f_req_i) |-> !(d_grant_o || d_viol_o || f_grant_o || f_viol_o)); // R7
  AST_OFF_NO_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_en_q |-> !(d_viol_o || f_viol_o)); // R11
  AST_TRAP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (d_viol_o || f_viol_o) |=> trap_o); // R8
  AST_TRAP_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(d_viol_o || f_viol_o)); // R8
  AST_ALARM_IN_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> trap_o); // R8
  AST_ENTRY_SET0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_entry_i |=> (act_set_q == '0)); // R9
  AST_USER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sup_i && !exc_entry_i) |=> ($stable(act_set_q) && $stable(prot_en_q))); // R10
endmodule

bind mem_guard mem_guard_chk #(.SET_W(SET_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_n),
  .sup_i       (sup_i),
  .exc_entry_i (exc_entry_i),
  .d_req_i     (d_req_i),
  .d_grant_o   (d_grant_o),
  .d_viol_o    (d_viol_o),
  .f_req_i     (f_req_i),
  .f_grant_o   (f_grant_o),
  .f_viol_o    (f_viol_o),
  .trap_o      (trap_o),
  .alarm_o     (alarm_o),
  .prot_en_q   (prot_en_q),
  .act_set_q   (act_set_q)
);

// File: tb/mem_guard_tb.sv
`timescale 1ns/1ps
module mem_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sup, exc, cfg_we, d_req, d_we, f_req;
  logic [2:0]  cfg_kind;
  logic [3:0]  cfg_idx;
  logic [31:0] cfg_wdata, cfg_rdata, d_addr, f_addr;
  logic        d_grant, d_viol, f_grant, f_viol, trap, alarm;

  always #10 clk = ~clk;

  mem_guard u_dut (
    .clk_i (clk), .rst_ni (rst_n), .sup_i (sup), .exc_entry_i (exc),
    .cfg_we_i (cfg_we), .cfg_kind_i (cfg_kind), .cfg_idx_i (cfg_idx),
    .cfg_wdata_i (cfg_wdata), .cfg_rdata_o (cfg_rdata),
    .d_req_i (d_req), .d_we_i (d_we), .d_addr_i (d_addr),
    .d_grant_o (d_grant), .d_viol_o (d_viol),
    .f_req_i (f_req), .f_addr_i (f_addr),
    .f_grant_o (f_grant), .f_viol_o (f_viol),
    .trap_o (trap), .alarm_o (alarm)
  );

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R12";
  bit    done = 0;

  // reference model state
  logic [31:0] m_dlo[16], m_dhi[16], m_clo[8], m_chi[8];
  logic [15:0] m_r[4], m_w[4];
  logic [7:0]  m_x[4];
  bit          m_en, m_al;
  int          m_set;
  bit          e_trap, e_alarm;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic bit m_dperm(logic [31:0] a, bit we);
    for (int i = 0; i < 16; i++) begin
      bit en = we ? m_w[m_set][i] : m_r[m_set][i];
      if (en && a >= m_dlo[i] && a < m_dhi[i]) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic bit m_fperm(logic [31:0] a);
    for (int i = 0; i < 8; i++)
      if (m_x[m_set][i] && a >= m_clo[i] && a < m_chi[i]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] m_rd(logic [2:0] k, logic [3:0] i);
    case (k)
      3'd0: return m_dlo[i];
      3'd1: return m_dhi[i];
      3'd2: return (i < 8) ? m_clo[i[2:0]] : 32'h0;
      3'd3: return (i < 8) ? m_chi[i[2:0]] : 32'h0;
      3'd4: return (i < 4) ? {16'h0, m_r[i[1:0]]} : 32'h0;
      3'd5: return (i < 4) ? {16'h0, m_w[i[1:0]]} : 32'h0;
      3'd6: return (i < 4) ? {24'h0, m_x[i[1:0]]} : 32'h0;
      default: return {28'h0, 2'(m_set), m_al, m_en};
    endcase
  endfunction

  function automatic bit e_dviol();
    return d_req && m_en && !m_dperm(d_addr, d_we);
  endfunction
  function automatic bit e_fviol();
    return f_req && m_en && !m_fperm(f_addr);
  endfunction

  // model update at the rising edge from the inputs held through the cycle
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_dlo[i] = 0; m_dhi[i] = 0; end
      for (int i = 0; i < 8; i++)  begin m_clo[i] = 0; m_chi[i] = 0; end
      for (int s = 0; s < 4; s++)  begin m_r[s] = 0; m_w[s] = 0; m_x[s] = 0; end
      m_en = 0; m_al = 0; m_set = 0; e_trap = 0; e_alarm = 0;
    end else begin
      e_trap  = e_dviol() || e_fviol();
      e_alarm = e_trap && m_al;
      if (cfg_we && sup) begin
        case (cfg_kind)
          3'd0: m_dlo[cfg_idx] = cfg_wdata & ~32'h7;
          3'd1: m_dhi[cfg_idx] = cfg_wdata & ~32'h7;
          3'd2: if (cfg_idx < 8) m_clo[cfg_idx[2:0]] = cfg_wdata & ~32'h1F;
          3'd3: if (cfg_idx < 8) m_chi[cfg_idx[2:0]] = cfg_wdata & ~32'h1F;
          3'd4: if (cfg_idx < 4) m_r[cfg_idx[1:0]] = cfg_wdata[15:0];
          3'd5: if (cfg_idx < 4) m_w[cfg_idx[1:0]] = cfg_wdata[15:0];
          3'd6: if (cfg_idx < 4) m_x[cfg_idx[1:0]] = cfg_wdata[7:0];
          default: begin
            m_en = cfg_wdata[0]; m_al = cfg_wdata[1]; m_set = int'(cfg_wdata[3:2]);
          end
        endcase
      end
      if (exc) m_set = 0;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit dv, fv;
      dv = e_dviol();
      fv = e_fviol();
      chk("d_viol",  32'(d_viol),  32'(dv));
      chk("d_grant", 32'(d_grant), 32'(d_req && !dv));
      chk("f_viol",  32'(f_viol),  32'(fv));
      chk("f_grant", 32'(f_grant), 32'(f_req && !fv));
      chk("trap",    32'(trap),    32'(e_trap));
      chk("alarm",   32'(alarm),   32'(e_alarm));
      chk("rdata",   cfg_rdata,    m_rd(cfg_kind, cfg_idx));
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cw(logic [2:0] k, logic [3:0] i, logic [31:0] d, bit s = 1'b1);
    cfg_kind = k; cfg_idx = i; cfg_wdata = d; cfg_we = 1'b1; sup = s;
    tick();
    cfg_we = 1'b0; sup = 1'b1;
    tick();  // readback of the written register
  endtask

  task automatic look(logic [2:0] k, logic [3:0] i);
    cfg_kind = k; cfg_idx = i;
    tick();
  endtask

  task automatic rd(logic [31:0] a);
    d_req = 1; d_we = 0; d_addr = a; tick(); d_req = 0; tick();
  endtask
  task automatic wr(logic [31:0] a);
    d_req = 1; d_we = 1; d_addr = a; tick(); d_req = 0; tick();
  endtask
  task automatic fetch(logic [31:0] a);
    f_req = 1; f_addr = a; tick(); f_req = 0; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; sup = 0; exc = 0; cfg_we = 0; cfg_kind = 0; cfg_idx = 0; cfg_wdata = 0;
    d_req = 0; d_we = 0; d_addr = 0; f_req = 0; f_addr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) tick();

    cur_req = "R12";  // everything reads back as zero
    for (int k = 0; k < 8; k++) look(3'(k), 4'd0);
    look(3'd0, 4'd15);

    cur_req = "R11";  // checking off: all granted
    rd(32'h1234); wr(32'h0); fetch(32'hFFFF_FFE0);

    cur_req = "R1";
    cw(3'd0, 4'd0, 32'h1000); cw(3'd1, 4'd0, 32'h1100);
    cw(3'd0, 4'd1, 32'h1080); cw(3'd1, 4'd1, 32'h1200);
    cw(3'd0, 4'd15, 32'h3000); cw(3'd1, 4'd15, 32'h3008);
    cw(3'd2, 4'd0, 32'h8000); cw(3'd3, 4'd0, 32'h8100);
    cw(3'd2, 4'd7, 32'h9000); cw(3'd3, 4'd7, 32'h9020);
    cw(3'd4, 4'd0, 32'h8001); cw(3'd5, 4'd0, 32'h0002); cw(3'd6, 4'd0, 32'h80);
    cw(3'd4, 4'd1, 32'h0002); cw(3'd5, 4'd1, 32'h0001); cw(3'd6, 4'd1, 32'h01);
    look(3'd0, 4'd1); look(3'd1, 4'd15); look(3'd3, 4'd7);
    cw(3'd7, 4'd0, 32'h1);

    cur_req = "R2";
    rd(32'h1000); rd(32'h10FF); rd(32'h1100); rd(32'h0FFF);

    cur_req = "R5";
    wr(32'h1090); wr(32'h1100); wr(32'h11FF); wr(32'h1200);

    cur_req = "R6";
    wr(32'h1050); rd(32'h1150); fetch(32'h1000);

    cur_req = "R3";
    fetch(32'h9000); fetch(32'h901F); fetch(32'h9020);
    cw(3'd2, 4'd7, 32'h901F); cw(3'd0, 4'd15, 32'h3007);
    rd(32'h3007); rd(32'h3008);

    cur_req = "R10";
    cw(3'd7, 4'd0, 32'h5, 1'b0); cw(3'd0, 4'd0, 32'h0, 1'b0); cw(3'd4, 4'd0, 32'h0, 1'b0);
    rd(32'h1000);

    cur_req = "R4";
    cw(3'd7, 4'd0, 32'h5);
    fetch(32'h8000); rd(32'h1000); rd(32'h1080); fetch(32'h9000); wr(32'h1000);

    cur_req = "R9";
    cfg_kind = 3'd7;
    exc = 1; rd(32'h1000); exc = 0;   // entry cycle still uses profile 1
    rd(32'h1000);
    cfg_kind = 3'd7; cfg_wdata = 32'h5; cfg_we = 1; exc = 1; tick();
    cfg_we = 0; exc = 0; tick();

    cur_req = "R8";
    cw(3'd7, 4'd0, 32'h3);
    d_req = 1; d_we = 0; d_addr = 32'h5000; f_req = 1; f_addr = 32'h0;
    tick(); tick(); d_req = 0; f_req = 0; tick(); tick();
    cw(3'd7, 4'd0, 32'h1);
    rd(32'h5000); rd(32'h1000);

    cur_req = "R11";
    cw(3'd7, 4'd0, 32'h2);
    rd(32'h5000); fetch(32'h0); wr(32'h7777_7770);

    cur_req = "R7";
    cw(3'd7, 4'd0, 32'h3);
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r = $urandom;
      d_req  = r[0];
      d_we   = r[1];
      d_addr = r[2] ? (32'h0FF0 + 32'($urandom % 32'h230)) : (32'h2FF8 + 32'($urandom % 32'h18));
      f_req  = r[3];
      f_addr = r[4] ? (32'h7FE0 + 32'($urandom % 32'h140)) : (32'h8FF0 + 32'($urandom % 32'h40));
      exc    = (r[7:5] == 3'd0);
      cfg_kind = 3'($urandom % 8);
      cfg_idx  = 4'($urandom % 16);
      if (r[11:8] == 4'd0) begin
        cfg_kind = 3'd7; cfg_wdata = {28'h0, r[15:12]}; cfg_we = 1; sup = r[16];
      end
      tick();
      cfg_we = 0; sup = 1; exc = 0;
    end
    d_req = 0; f_req = 0;
    tick(); tick();
    finish_run();
  end
endmodule